// File: doc/BRIEF.md
# Dead-Band Frequency-Lock Loop Controller

This block holds an oscillator near a programmed frequency by repeatedly measuring it and nudging a PWM duty value, which an external filter turns into the oscillator's tuning voltage. The oscillator reaches the block already divided down by an external prescaler. The block divides it further by a small internal prescaler and counts the result over a fixed gate of `GATE_CYCLES` reference clocks (one second in normal use). It then scales the count back to hertz by shifting it left by the combined prescaler exponent. This gives a resolution of 1024 Hz with the default exponents.

After each measurement the block forms the error, setpoint minus measured frequency. It divides the magnitude of the error by a programmable divisor, truncating, and adds the signed quotient to a duty accumulator that saturates at both ends. Truncation does two jobs. It sets the loop gain, and it opens a dead band: while the error is smaller than the divisor, the duty value does not move at all. The tuning voltage therefore stays perfectly still once the oscillator is close enough. A loop-disable control and a zero divisor both hand the duty value over to a manual register. The accumulator follows that register, so the loop resumes from the manual value when it is enabled again.

Top module: `fll_deadband_ctrl`

## Requirements
- R1: A measurement completes every `GATE_CYCLES` reference cycles, and each one produces exactly one single-cycle pulse on `upd_o`, so consecutive pulses are exactly `GATE_CYCLES` cycles apart.
- R2: `freq_hz_o` equals (rising edges of `osc_i` in one gate window, divided by 2^`INT_PRE_LOG2` by a free-running internal prescaler) shifted left by `INT_PRE_LOG2`+`EXT_PRE_LOG2` bits. With the defaults this is carries times 1024.
- R3: With the loop active, each update adds trunc((setpoint − measured)/divisor) to the duty value. The division truncates toward zero, so an error of −25000 with divisor 10000 gives −2.
- R4: When |setpoint − measured| is less than the divisor, the duty value is unchanged by the update. An error magnitude exactly equal to the divisor moves it by one step in the error's direction.
- R5: Corrections accumulate over successive updates, and the duty value does not change between updates while the loop is active.
- R6: The duty value saturates at 0 and at 2^`DUTY_W`−1 instead of wrapping.
- R7: With `loop_en_i` low, `duty_o` equals the `manual_duty_i` value of the previous cycle. When the loop is enabled, the first correction starts from that manual value.
- R8: A divisor of zero behaves exactly like `loop_en_i` low, even with `loop_en_i` high.
- R9: `pwm_o` has a period of 2^`DUTY_W`·`PWM_PRE` reference cycles and is high for `duty_o`·`PWM_PRE` of them. A duty of 0 keeps it permanently low.
- R10: The internal edge count saturates at 2^`CNT_W`−1, and the measurement then reports that maximum. Saturation sets `ovf_o`, which stays set until reset.
- R11: After reset `duty_o`, `freq_hz_o`, `upd_o`, `ovf_o` and `pwm_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_i | input | 1 | Externally prescaled oscillator, asynchronous |
| setpoint_i | input | FREQ_W | Target frequency in hertz |
| divisor_i | input | DIV_W | Error divisor (gain and dead-band width); 0 disables the loop |
| loop_en_i | input | 1 | 1 = closed loop, 0 = manual duty |
| manual_duty_i | input | DUTY_W | Duty value used while the loop is off |
| pwm_o | output | 1 | PWM tuning output |
| duty_o | output | DUTY_W | Current duty value |
| freq_hz_o | output | FREQ_W | Latest measured frequency in hertz |
| upd_o | output | 1 | One-cycle pulse when a measurement and its correction are complete |
| ovf_o | output | 1 | Sticky edge-counter saturation flag |

## Verification
The bench builds the block with a 600-cycle gate, a 6-bit edge counter, `PWM_PRE` of 1, and otherwise default widths. The short gate makes dozens of corrections fit in a short run. This brings the dead-band edges on both sides, truncation toward zero, accumulation and saturation at both duty limits within reach. The narrow counter lets an input toggling every reference cycle saturate the count, so the sticky overflow flag can be observed. The 1024-cycle PWM period allows high-time counts over a full period at duty 0, mid-range and full scale.

// File: rtl/fll_pkg.sv
package fll_pkg;

  // Correction sequencer: waiting for a measurement, or dividing the error.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DIV  = 1'b1
  } upd_state_e;

endpackage

// File: rtl/fll_edge_sync.sv
module fll_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
      rise_o <= sync_q[STAGES-1] & ~last_q;
    end
  end

endmodule

// File: rtl/fll_freq_meter.sv
module fll_freq_meter #(
  parameter int unsigned GATE_CYCLES  = 100_000_000,
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned INT_PRE_LOG2 = 2,
  parameter int unsigned SCALE_SH     = 10,
  parameter int unsigned FREQ_W       = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_i,
  output logic              stb_o,
  output logic [FREQ_W-1:0] hz_o,
  output logic              ovf_o
);

  localparam int unsigned GW = $clog2(GATE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [INT_PRE_LOG2-1:0] pre_q;
  logic [GW-1:0]           gate_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        cnt_nx;
  logic                    carry;
  logic                    sat_hit;
  logic                    gate_end;

  assign carry    = edge_i && (pre_q == '1);
  assign gate_end = (gate_q == GW'(GATE_CYCLES - 1));

  always_comb begin
    sat_hit = 1'b0;
    cnt_nx  = cnt_q;
    if (carry) begin
      if (cnt_q == CNT_MAX) sat_hit = 1'b1;
      else                  cnt_nx  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      gate_q <= '0;
      cnt_q  <= '0;
      stb_o  <= 1'b0;
      hz_o   <= '0;
      ovf_o  <= 1'b0;
    end else begin
      pre_q <= pre_q + INT_PRE_LOG2'(edge_i);
      stb_o <= gate_end;
      if (sat_hit) ovf_o <= 1'b1;
      if (gate_end) begin
        gate_q <= '0;
        cnt_q  <= '0;
        hz_o   <= FREQ_W'(cnt_nx) << SCALE_SH;
      end else begin
        gate_q <= gate_q + 1'b1;
        cnt_q  <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/fll_divu.sv
module fll_divu #(
  parameter int unsigned W  = 36,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [W-1:0]  num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [W-1:0]  quo_o
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  num_q;
  logic [DW-1:0] den_q;
  logic [DW-1:0] rem_q;
  logic [CW-1:0] left_q;
  logic          busy_q;
  logic [DW:0]   rem_sh;
  logic          ge;

  // One quotient bit per cycle, restoring form; the quotient shifts into num_q.
  assign rem_sh = {rem_q, num_q[W-1]};
  assign ge     = (rem_sh >= {1'b0, den_q});
  assign quo_o  = num_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        num_q  <= num_i;
        den_q  <= den_i;
        rem_q  <= '0;
        left_q <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        num_q  <= {num_q[W-2:0], ge};
        rem_q  <= ge ? (rem_sh[DW-1:0] - den_q) : rem_sh[DW-1:0];
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fll_pwm.sv
module fll_pwm #(
  parameter int unsigned DUTY_W = 10,
  parameter int unsigned PRE    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);

  localparam int unsigned PW = (PRE > 1) ? $clog2(PRE) : 1;

  logic [PW-1:0]     pre_q;
  logic [DUTY_W-1:0] step_q;
  logic [DUTY_W-1:0] duty_q;
  logic              tick;

  assign tick = (pre_q == PW'(PRE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      step_q <= '0;
      duty_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        step_q <= step_q + 1'b1;
        // New duty takes effect only at a period boundary.
        if (step_q == '1) duty_q <= duty_i;
      end
      pwm_o <= (step_q < duty_q);
    end
  end

endmodule

// File: rtl/fll_deadband_ctrl.sv
module fll_deadband_ctrl
  import fll_pkg::*;
#(
  parameter int unsigned GATE_CYCLES  = 100_000_000,
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned INT_PRE_LOG2 = 2,
  parameter int unsigned EXT_PRE_LOG2 = 8,
  parameter int unsigned FREQ_W       = 36,
  parameter int unsigned DIV_W        = 24,
  parameter int unsigned DUTY_W       = 10,
  parameter int unsigned PWM_PRE      = 1,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_i,
  input  logic [FREQ_W-1:0] setpoint_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              loop_en_i,
  input  logic [DUTY_W-1:0] manual_duty_i,
  output logic              pwm_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [FREQ_W-1:0] freq_hz_o,
  output logic              upd_o,
  output logic              ovf_o
);

  localparam int unsigned SCALE_SH = INT_PRE_LOG2 + EXT_PRE_LOG2;
  localparam int unsigned SW       = FREQ_W + 1;
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  logic              osc_rise;
  logic              meas_stb;
  logic [FREQ_W-1:0] meas_hz;
  logic              loop_on;
  logic              err_neg;
  logic [FREQ_W-1:0] err_mag;
  logic              div_start;
  logic              div_done;
  logic [FREQ_W-1:0] quo;
  upd_state_e        state_q;
  logic              neg_q;
  logic [DUTY_W-1:0] acc_q;
  logic [SW-1:0]     sum_up;
  logic [DUTY_W-1:0] acc_nx;

  fll_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(osc_i), .rise_o(osc_rise)
  );

  fll_freq_meter #(
    .GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W), .INT_PRE_LOG2(INT_PRE_LOG2),
    .SCALE_SH(SCALE_SH), .FREQ_W(FREQ_W)
  ) u_meter (
    .clk(clk), .rst(rst), .edge_i(osc_rise),
    .stb_o(meas_stb), .hz_o(meas_hz), .ovf_o(ovf_o)
  );

  assign loop_on = loop_en_i && (divisor_i != '0);

  // Sign and magnitude of the error, so truncation is symmetric about zero.
  always_comb begin
    if (setpoint_i >= meas_hz) begin
      err_neg = 1'b0;
      err_mag = setpoint_i - meas_hz;
    end else begin
      err_neg = 1'b1;
      err_mag = meas_hz - setpoint_i;
    end
  end

  assign div_start = meas_stb && loop_on && (state_q == ST_IDLE);

  fll_divu #(.W(FREQ_W), .DW(DIV_W)) u_div (
    .clk(clk), .rst(rst), .start_i(div_start), .num_i(err_mag),
    .den_i(divisor_i), .done_o(div_done), .quo_o(quo)
  );

  // Saturating signed add of the quotient to the duty accumulator.
  always_comb begin
    sum_up = {1'b0, quo} + SW'(acc_q);
    if (neg_q)
      acc_nx = (quo > FREQ_W'(acc_q)) ? '0 : (acc_q - quo[DUTY_W-1:0]);
    else
      acc_nx = (sum_up > SW'(DUTY_MAX)) ? DUTY_MAX : sum_up[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      neg_q     <= 1'b0;
      acc_q     <= '0;
      upd_o     <= 1'b0;
      freq_hz_o <= '0;
    end else begin
      upd_o <= 1'b0;
      if (meas_stb) freq_hz_o <= meas_hz;
      unique case (state_q)
        ST_IDLE: begin
          if (meas_stb) begin
            if (loop_on) begin
              state_q <= ST_DIV;
              neg_q   <= err_neg;
            end else begin
              upd_o <= 1'b1;
            end
          end
        end
        ST_DIV: begin
          if (div_done) begin
            state_q <= ST_IDLE;
            upd_o   <= 1'b1;
          end
        end
      endcase
      if (!loop_on)
        acc_q <= manual_duty_i;
      else if ((state_q == ST_DIV) && div_done)
        acc_q <= acc_nx;
    end
  end

  assign duty_o = acc_q;

  fll_pwm #(.DUTY_W(DUTY_W), .PRE(PWM_PRE)) u_pwm (
    .clk(clk), .rst(rst), .duty_i(acc_q), .pwm_o(pwm_o)
  );

endmodule

// File: rtl/fll_deadband_chk.sv
module fll_deadband_chk #(
  parameter int unsigned FREQ_W = 36,
  parameter int unsigned DIV_W  = 24,
  parameter int unsigned DUTY_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [FREQ_W-1:0] setpoint_i,
  input logic [DIV_W-1:0]  divisor_i,
  input logic              loop_en_i,
  input logic [DUTY_W-1:0] manual_duty_i,
  input logic [DUTY_W-1:0] duty_o,
  input logic [FREQ_W-1:0] freq_hz_o,
  input logic              upd_o,
  input logic              ovf_o
);

  logic              loop_on;
  logic              zero_div;
  logic [FREQ_W-1:0] gap;
  logic              in_band;

  assign loop_on  = loop_en_i && (divisor_i != '0);
  assign zero_div = loop_en_i && (divisor_i == '0);
  assign gap      = (setpoint_i >= freq_hz_o) ? (setpoint_i - freq_hz_o)
                                              : (freq_hz_o - setpoint_i);
  assign in_band  = (gap < FREQ_W'(divisor_i));

  assert_upd_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o);

  assert_dead_band_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_o && loop_on && $past(loop_on) && in_band) |-> (duty_o == $past(duty_o)));

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (rst)
    (loop_on && $past(loop_on) && !upd_o) |-> $stable(duty_o));

  assert_manual_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(loop_en_i)) |-> (duty_o == $past(manual_duty_i)));

  assert_zero_div_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(zero_div)) |-> (duty_o == $past(manual_duty_i)));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(ovf_o) |-> ovf_o);

endmodule

bind fll_deadband_ctrl fll_deadband_chk #(
  .FREQ_W(FREQ_W), .DIV_W(DIV_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk(clk), .rst(rst), .setpoint_i(setpoint_i), .divisor_i(divisor_i),
  .loop_en_i(loop_en_i), .manual_duty_i(manual_duty_i), .duty_o(duty_o),
  .freq_hz_o(freq_hz_o), .upd_o(upd_o), .ovf_o(ovf_o)
);

// File: tb/fll_deadband_ctrl_test.sv
module fll_deadband_ctrl_test;

  localparam int unsigned FREQ_W = 36;
  localparam int unsigned DIV_W  = 24;
  localparam int unsigned DUTY_W = 10;
  localparam int unsigned GATE   = 600;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              osc = 1'b0;
  logic [FREQ_W-1:0] setpoint = '0;
  logic [DIV_W-1:0]  divisor = '0;
  logic              loop_en = 1'b0;
  logic [DUTY_W-1:0] manual = '0;
  logic              pwm;
  logic [DUTY_W-1:0] duty;
  logic [FREQ_W-1:0] freq;
  logic              upd;
  logic              ovf;

  int half = 3;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  always begin
    repeat (half) @(negedge clk);
    osc = ~osc;
  end

  fll_deadband_ctrl #(
    .GATE_CYCLES(GATE), .CNT_W(6), .FREQ_W(FREQ_W), .DIV_W(DIV_W),
    .DUTY_W(DUTY_W), .PWM_PRE(1)
  ) uut (
    .clk(clk), .rst(rst), .osc_i(osc), .setpoint_i(setpoint),
    .divisor_i(divisor), .loop_en_i(loop_en), .manual_duty_i(manual),
    .pwm_o(pwm), .duty_o(duty), .freq_hz_o(freq), .upd_o(upd), .ovf_o(ovf)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_upd(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!upd);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    int c;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 duty after reset", duty, 0);
    check("R11 freq after reset", freq, 0);
    check("R11 upd after reset", upd, 0);
    check("R11 ovf after reset", ovf, 0);
    check("R11 pwm after reset", pwm, 0);
    c = 0;
  endtask

  task automatic t_gate();
    int c;
    wait_upd(c);
    wait_upd(c);
    check("R1 update spacing", c, GATE);
    @(negedge clk);
    check("R1 update pulse width", upd, 0);
  endtask

  task automatic t_measure();
    int c;
    half = 3;  wait_upd(c); wait_upd(c);
    check("R2 period 6 -> 25 carries", freq, 25 * 1024);
    half = 5;  wait_upd(c); wait_upd(c);
    check("R2 period 10 -> 15 carries", freq, 15 * 1024);
    half = 15; wait_upd(c); wait_upd(c);
    check("R2 period 30 -> 5 carries", freq, 5 * 1024);
    half = 3;  wait_upd(c); wait_upd(c);
    check("R2 back to period 6", freq, 25 * 1024);
  endtask

  task automatic pwm_high(input int d, output int hi);
    manual = DUTY_W'(d);
    repeat (2100) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
  endtask

  task automatic t_pwm();
    int hi;
    pwm_high(300, hi);
    check("R7 manual duty", duty, 300);
    check("R9 pwm high time 300", hi, 300);
    pwm_high(0, hi);
    check("R9 pwm never high at 0", hi, 0);
    pwm_high(1023, hi);
    check("R9 pwm high time 1023", hi, 1023);
  endtask

  task automatic t_loop();
    int c;
    manual = 10'd500;
    wait_upd(c);
    settle();
    divisor = 24'd10000;
    setpoint = 36'd60600;
    loop_en = 1'b1;
    wait_upd(c);
    check("R3 R7 first correction from manual +3", duty, 503);
    check("R2 measured in loop", freq, 25600);
    wait_upd(c);
    check("R5 accumulate +3", duty, 506);
    settle(); setpoint = 36'd600;
    wait_upd(c);
    check("R3 truncate toward zero -2", duty, 504);
    wait_upd(c);
    check("R3 R5 second -2", duty, 502);
  endtask

  task automatic t_band();
    int c;
    settle(); setpoint = 36'd35599;
    wait_upd(c); check("R4 +9999 in band", duty, 502);
    wait_upd(c); check("R4 +9999 still frozen", duty, 502);
    settle(); setpoint = 36'd15601;
    wait_upd(c); check("R4 -9999 in band", duty, 502);
    settle(); setpoint = 36'd35600;
    wait_upd(c); check("R4 +10000 one step up", duty, 503);
    settle(); setpoint = 36'd15600;
    wait_upd(c); check("R4 -10000 one step down", duty, 502);
  endtask

  task automatic t_sat();
    int c;
    settle(); divisor = 24'd1; setpoint = 36'd1 << 34;
    wait_upd(c); check("R6 clamp high", duty, 1023);
    wait_upd(c); check("R6 stays high", duty, 1023);
    settle(); setpoint = '0;
    wait_upd(c); check("R6 clamp low", duty, 0);
    wait_upd(c); check("R6 stays low", duty, 0);
  endtask

  task automatic t_zero_div();
    int c;
    settle(); divisor = '0; manual = 10'd77;
    repeat (3) @(negedge clk);
    check("R8 zero divisor follows manual", duty, 77);
    wait_upd(c);
    check("R8 zero divisor across update", duty, 77);
    settle(); divisor = 24'd10000; setpoint = 36'd60600;
    wait_upd(c);
    check("R8 R7 resume from manual +3", duty, 80);
  endtask

  task automatic t_overflow();
    int c;
    settle(); loop_en = 1'b0;
    check("R10 no overflow yet", ovf, 0);
    half = 1; wait_upd(c); wait_upd(c);
    check("R10 saturated measurement", freq, 63 * 1024);
    check("R10 overflow set", ovf, 1);
    half = 3; wait_upd(c); wait_upd(c);
    check("R10 normal measurement again", freq, 25600);
    check("R10 overflow sticky", ovf, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_gate();
    t_measure();
    t_pwm();
    t_loop();
    t_band();
    t_sat();
    t_zero_div();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule